// File: doc/BRIEF.md
# Timestamp pulse capture unit

This block timestamps timing-sync pulses from an external comparator. The comparator output reaches the block with no relation to its clock. It is synchronized, and each rising edge that arrives while the block is running takes a snapshot of a free-running 64-bit time counter. That counter is supplied in carry-save form, as a sum vector and a carry vector. The block adds the two vectors to get the binary time. It then presents a three-word record to the host: the pulse sequence number, the upper 32 bits of the time and the lower 32 bits of the time.

The host drains the record through a valid/ready word stream. `rec_valid` plays the role of the have-data flag, and each accepted transfer is a pump that moves to the next word. There is no record queue. A pulse that arrives while a record is still outstanding is not stored. It still advances the sequence number, so the host sees the gap, and it raises a sticky missed-pulse interrupt. A synchronous reset clears all of the block's own state; the external counter is not touched. A run enable freezes the block while it is low.

Back-pressure rules: a word is transferred on a clock edge where `rec_valid`, `rec_ready` and `run_en` are all high. While no transfer happens, `rec_valid` and `rec_data` hold their values. The host may keep `rec_ready` high at any time.

Top module: `sync_stamp_unit`

## Requirements
- R1: With `cmp_in` going high between two clock edges, the capture samples `cnt_sum`/`cnt_carry` at the third rising clock edge after that change, and `rec_valid` first reads high after the fourth edge. `cmp_in` must stay low for at least two cycles between pulses.
- R2: The captured timestamp equals `cnt_sum + cnt_carry` modulo 2^64, as sampled at the capture edge. Later changes of the counter inputs do not alter it.
- R3: A record is exactly three words in this order: the sequence number, timestamp bits 63:32, then timestamp bits 31:0. `rec_valid` reads low after the third transfer.
- R4: While `rec_valid` is high and no transfer takes place, `rec_valid` stays high and `rec_data` is unchanged.
- R5: Every rising edge seen while `run_en` is high increments a 32-bit pulse counter, including edges that are missed. A record carries the counter value that includes its own pulse, so the first pulse after reset carries 1.
- R6: An edge seen while a record is pending sets `miss_irq`. A record is pending from its capture edge until its third transfer. The pending record's words are left unchanged.
- R7: `miss_irq` stays set until `rst` or until `miss_clr` is high at a clock edge. A new miss in the same cycle wins over the clear.
- R8: While `run_en` is low, edges on `cmp_in` are ignored (not captured, not counted, not stored for later) and no word is transferred regardless of `rec_ready`.
- R9: `rst` high at a clock edge clears `rec_valid`, `miss_irq`, the pulse counter and any pending record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous reset of the block state, active high |
| run_en | input | 1 | High: running; low: paused |
| cmp_in | input | 1 | Asynchronous comparator output |
| cnt_sum | input | 64 | Sum vector of the carry-save time counter |
| cnt_carry | input | 64 | Carry vector of the carry-save time counter |
| rec_valid | output | 1 | A record word is available |
| rec_ready | input | 1 | Host accepts the current word |
| rec_data | output | 32 | Current record word |
| miss_irq | output | 1 | Sticky missed-pulse interrupt |
| miss_clr | input | 1 | Clears `miss_irq` |

## Verification
The hardest state to reach is a second edge landing while a record is still pending. In that state the counter must jump, the interrupt must set, and the pending words must survive untouched. The bench captures one pulse and deliberately does not drain it. It then fires a second pulse and only afterwards pulls the three words, so the first record's values are read out after the miss. A third pulse then shows the gap in the sequence. The counter inputs change every cycle, with the time split unevenly across sum and carry. Pulses are placed across a 32-bit boundary and across the 64-bit wrap, so a wrong capture cycle or a carry dropped between words shows up at the outputs.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE    = 2'd0,
    CAP_RESOLVE = 2'd1,
    CAP_SEND    = 2'd2
  } cap_state_e;

  function automatic int unsigned words_for(input int unsigned bits,
                                            input int unsigned width);
    return (bits + width - 1) / width;
  endfunction

endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R1: an edge is reported for exactly one cycle
  a_r1_rise_once: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/stamp_resolve.sv
module stamp_resolve #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic [TS_W-1:0] sum_i,
  input  logic [TS_W-1:0] carry_i,
  output logic            done_o,
  output logic [TS_W-1:0] ts_o
);

  logic            pend_q;
  logic [TS_W-1:0] sum_q;
  logic [TS_W-1:0] carry_q;

  always_ff @(posedge clk) begin
    if (rst)                  pend_q <= 1'b0;
    else if (load_i)          pend_q <= 1'b1;
    else if (pend_q && adv_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      sum_q   <= sum_i;
      carry_q <= carry_i;
    end
  end

  assign ts_o   = sum_q + carry_q;
  assign done_o = pend_q & adv_i;

  // R2: a snapshot is never replaced before it is handed on
  a_r2_no_reload: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !pend_q);

  // R8: a held snapshot waits while paused
  a_r8_resolve_wait: assert property (@(posedge clk) disable iff (rst)
    pend_q && !adv_i |=> pend_q);

endmodule

// File: rtl/stamp_word_pump.sv
module stamp_word_pump #(
  parameter int TS_W   = 64,
  parameter int WORD_W = 32,
  parameter int SEQ_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              drained_o
);

  localparam int TS_WORDS = stamp_pkg::words_for(TS_W, WORD_W);
  localparam int NWORDS   = 1 + TS_WORDS;
  localparam int IDX_W    = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic [WORD_W-1:0] word_q [NWORDS];
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;
  logic              fire;
  logic              at_last;

  assign fire    = valid_q & ready_i & run_i;
  assign at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (load_i) begin
      word_q[0] <= WORD_W'(seq_i);
      for (int k = 1; k < NWORDS; k++) begin
        word_q[k] <= ts_i[TS_W-1-(k-1)*WORD_W -: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
    end else if (fire) begin
      if (at_last) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = word_q[idx_q];
  assign drained_o = fire & at_last;

  // R4: a stalled word keeps its value
  a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
    valid_o && !(ready_i && run_i) |=> valid_o && $stable(data_o));

  // R3: the word index stays within one record
  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < NWORDS);

  // R6: a pending record is never overwritten
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !valid_q);

endmodule

// File: rtl/sync_stamp_unit.sv
module sync_stamp_unit #(
  parameter int TS_W        = 64,
  parameter int WORD_W      = 32,
  parameter int SEQ_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              cmp_in,
  input  logic [TS_W-1:0]   cnt_sum,
  input  logic [TS_W-1:0]   cnt_carry,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [WORD_W-1:0] rec_data,
  output logic              miss_irq,
  input  logic              miss_clr
);

  import stamp_pkg::*;

  cap_state_e       state_q;
  logic             rise;
  logic             accept;
  logic             take;
  logic             busy;
  logic             res_done;
  logic [TS_W-1:0]  res_ts;
  logic             drained;
  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] rec_seq_q;
  logic             miss_q;

  stamp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (cmp_in),
    .rise_o  (rise)
  );

  assign accept = rise & run_en;
  assign busy   = (state_q != CAP_IDLE);
  assign take   = accept & ~busy;

  stamp_resolve #(.TS_W(TS_W)) u_resolve (
    .clk     (clk),
    .rst     (rst),
    .load_i  (take),
    .adv_i   (run_en),
    .sum_i   (cnt_sum),
    .carry_i (cnt_carry),
    .done_o  (res_done),
    .ts_o    (res_ts)
  );

  stamp_word_pump #(.TS_W(TS_W), .WORD_W(WORD_W), .SEQ_W(SEQ_W)) u_pump (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_en),
    .load_i    (res_done),
    .seq_i     (rec_seq_q),
    .ts_i      (res_ts),
    .ready_i   (rec_ready),
    .valid_o   (rec_valid),
    .data_o    (rec_data),
    .drained_o (drained)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CAP_IDLE;
    end else begin
      unique case (state_q)
        CAP_IDLE:    if (take)     state_q <= CAP_RESOLVE;
        CAP_RESOLVE: if (res_done) state_q <= CAP_SEND;
        CAP_SEND:    if (drained)  state_q <= CAP_IDLE;
        default:                   state_q <= CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= '0;
      rec_seq_q <= '0;
    end else if (accept) begin
      seq_q <= seq_q + 1'b1;
      if (take) rec_seq_q <= seq_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 miss_q <= 1'b0;
    else if (accept && busy) miss_q <= 1'b1;
    else if (miss_clr)       miss_q <= 1'b0;
  end

  assign miss_irq = miss_q;

  // R6: an edge during an outstanding record raises the interrupt
  a_r6_miss_on_busy: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rise && run_en |=> miss_irq);

  // R7: a clear with no competing miss drops the interrupt
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    miss_clr && !(accept && busy) |=> !miss_irq);

  // R8: nothing moves at the outputs while paused
  a_r8_pause_freeze: assert property (@(posedge clk) disable iff (rst)
    !run_en && !miss_clr |=> $stable(miss_irq) && $stable(rec_valid));

  // R3: the control state and the word stream agree
  a_r3_send_valid: assert property (@(posedge clk) disable iff (rst)
    state_q == CAP_SEND |-> rec_valid);

endmodule

// File: tb/sync_stamp_unit_tb_top.sv
module sync_stamp_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SPLIT_MASK = 64'hC3A5_0F96_5A3C_F00F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        cmp_in = 1'b0;
  logic        rec_ready = 1'b0;
  logic        miss_clr = 1'b0;
  logic        rec_valid;
  logic [31:0] rec_data;
  logic        miss_irq;
  logic [63:0] cnt_sum;
  logic [63:0] cnt_carry;
  logic [63:0] base = 64'h0000_0000_0000_1000;
  logic [63:0] cyc = '0;
  logic [63:0] t_now;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] exp_seq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc = cyc + 1;

  assign t_now     = base + cyc;
  assign cnt_carry = {t_now[20:0], t_now[63:21]} ^ SPLIT_MASK;
  assign cnt_sum   = t_now - cnt_carry;

  sync_stamp_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cmp_in    (cmp_in),
    .cnt_sum   (cnt_sum),
    .cnt_carry (cnt_carry),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_data  (rec_data),
    .miss_irq  (miss_irq),
    .miss_clr  (miss_clr)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_time(input logic [63:0] target);
    base = target - cyc;
  endtask

  // raises cmp_in, returns the counter value at that moment
  task automatic fire_pulse(output logic [63:0] t0);
    @(negedge clk);
    #1;
    cmp_in = 1'b1;
    t0 = t_now;
    repeat (3) @(negedge clk);
    #1;
    cmp_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pull(output logic [31:0] w, input string tag);
    int guard = 0;
    @(negedge clk);
    while (!rec_valid && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    check(rec_valid, tag, {63'd0, rec_valid}, 64'd1);
    w = rec_data;
    #1 rec_ready = 1'b1;
    @(negedge clk);
    #1 rec_ready = 1'b0;
  endtask

  task automatic drain_check(input logic [31:0] s, input logic [63:0] ts,
                             input string tag);
    logic [31:0] w;
    pull(w, {tag, " R3 word0"});
    check(w == s, {tag, " R5 sequence word"}, {32'd0, w}, {32'd0, s});
    pull(w, {tag, " R3 word1"});
    check(w == ts[63:32], {tag, " R2 upper word"}, {32'd0, w}, {32'd0, ts[63:32]});
    pull(w, {tag, " R3 word2"});
    check(w == ts[31:0], {tag, " R2 lower word"}, {32'd0, w}, {32'd0, ts[31:0]});
    @(negedge clk);
    check(!rec_valid, {tag, " R3 valid low after third transfer"},
          {63'd0, rec_valid}, 64'd0);
  endtask

  task automatic t_reset_state;
    check(!rec_valid, "R9 reset valid", {63'd0, rec_valid}, 64'd0);
    check(!miss_irq, "R9 reset miss", {63'd0, miss_irq}, 64'd0);
  endtask

  task automatic t_capture_timing;
    logic [63:0] t0;
    set_time(64'h0000_0001_FFFF_FFF0);
    @(negedge clk);
    #1;
    cmp_in = 1'b1;
    t0 = t_now;
    repeat (3) @(negedge clk);
    check(!rec_valid, "R1 valid low after third edge", {63'd0, rec_valid}, 64'd0);
    @(negedge clk);
    check(rec_valid, "R1 valid high after fourth edge", {63'd0, rec_valid}, 64'd1);
    #1 cmp_in = 1'b0;
    repeat (2) @(negedge clk);
    exp_seq++;
    drain_check(exp_seq, t0 + 64'd2, "capture");
  endtask

  task automatic t_word_carry;
    logic [63:0] t0;
    set_time(64'h0000_0001_FFFF_FFFC);
    fire_pulse(t0);
    exp_seq++;
    drain_check(exp_seq, t0 + 64'd2, "R2 32-bit boundary");
    set_time(64'hFFFF_FFFF_FFFF_FFFE);
    fire_pulse(t0);
    exp_seq++;
    drain_check(exp_seq, t0 + 64'd2, "R2 64-bit wrap");
  endtask

  task automatic t_backpressure;
    logic [63:0] t0;
    logic [31:0] w0;
    fire_pulse(t0);
    exp_seq++;
    w0 = rec_data;
    repeat (5) @(negedge clk);
    check(rec_valid, "R4 valid held", {63'd0, rec_valid}, 64'd1);
    check(rec_data == w0 && w0 == exp_seq, "R4 word held",
          {32'd0, rec_data}, {32'd0, exp_seq});
    drain_check(exp_seq, t0 + 64'd2, "backpressure");
  endtask

  task automatic t_missed;
    logic [63:0] ta;
    logic [63:0] tb;
    logic [63:0] tc;
    fire_pulse(ta);
    exp_seq++;
    check(!miss_irq, "R6 no miss on first pulse", {63'd0, miss_irq}, 64'd0);
    fire_pulse(tb);
    check(miss_irq, "R6 miss raised", {63'd0, miss_irq}, 64'd1);
    drain_check(exp_seq, ta + 64'd2, "R6 pending record kept");
    exp_seq++;
    check(miss_irq, "R7 miss sticky", {63'd0, miss_irq}, 64'd1);
    #1 miss_clr = 1'b1;
    @(negedge clk);
    #1 miss_clr = 1'b0;
    check(!miss_irq, "R7 miss cleared", {63'd0, miss_irq}, 64'd0);
    fire_pulse(tc);
    exp_seq++;
    drain_check(exp_seq, tc + 64'd2, "R5 gap visible");
  endtask

  task automatic t_pause;
    logic [63:0] t0;
    #1 run_en = 1'b0;
    fire_pulse(t0);
    repeat (3) @(negedge clk);
    check(!rec_valid, "R8 edge ignored while paused", {63'd0, rec_valid}, 64'd0);
    #1 run_en = 1'b1;
    repeat (6) @(negedge clk);
    check(!rec_valid, "R8 edge not kept for later", {63'd0, rec_valid}, 64'd0);
    fire_pulse(t0);
    exp_seq++;
    #1;
    run_en = 1'b0;
    rec_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(rec_valid && rec_data == exp_seq, "R8 no transfer while paused",
          {32'd0, rec_data}, {32'd0, exp_seq});
    #1;
    rec_ready = 1'b0;
    run_en = 1'b1;
    drain_check(exp_seq, t0 + 64'd2, "R8 resume");
  endtask

  task automatic t_reset_mid;
    logic [63:0] t0;
    fire_pulse(t0);
    fire_pulse(t0);
    check(miss_irq && rec_valid, "R9 setup pending and missed",
          {62'd0, miss_irq, rec_valid}, 64'd3);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    check(!rec_valid, "R9 valid cleared", {63'd0, rec_valid}, 64'd0);
    check(!miss_irq, "R9 miss cleared", {63'd0, miss_irq}, 64'd0);
    fire_pulse(t0);
    exp_seq = 32'd1;
    drain_check(exp_seq, t0 + 64'd2, "R9 counter restarted");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    #1;
    rst = 1'b0;
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    t_capture_timing();
    t_word_carry();
    t_backpressure();
    t_missed();
    t_pause();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule